// File: doc/BRIEF.md
# Nested Transaction Scope Controller

This block tracks nested hardware transactional regions for a small processor core. The core reports three kinds of event: a transaction opening, a transaction closing, and an abort condition that other logic has detected. From these events the controller keeps an active flag and a nesting depth. When the outermost scope opens, it saves the recovery address that goes with that scope. When the outermost scope closes, it asks an external checkpoint unit to make the speculative state permanent.

Any failure empties every open level in a single step. A failure is a refused commit, an abort condition signalled by the core, or an opening event that would push the depth past its configured limit. On a failure the controller pulses a register-rollback request and a memory-discard request. It also redirects the core to the saved recovery address and latches a status code that states the cause. A closing event that arrives while no transaction is open raises a protection fault pulse and leaves all other state as it was.

Top module: `txn_nest_ctrl`

## Requirements
- R1: A close event while `active_o` is 0 gives `fault_o` high for exactly the one cycle after the clock edge that samples the event. Depth, `active_o`, `status_o`, `redirect_valid_o` and `rollback_o` all stay unchanged.
- R2: An open event sets `active_o` and adds one to `depth_o`. `begin_fallback_i` is saved only when the depth goes from 0 to 1. Open events at inner levels never replace the saved address.
- R3: A close event while active subtracts one from the depth. `commit_valid_o` is raised only when that subtraction brings the depth to 0. Inner close events raise no commit request.
- R4: `commit_valid_o` stays high until it is sampled together with `commit_ready_i`. While a commit is outstanding, from the closing edge until the response arrives, `evt_ready_o` is 0 and open and close events are ignored.
- R5: When `commit_resp_valid_i` is 1 and `commit_resp_ok_i` is 1, `active_o` clears. No redirect, rollback or discard follows, and `status_o` keeps its value.
- R6: A refused commit (`commit_resp_valid_i`=1, `commit_resp_ok_i`=0) is handled as an abort. In the next cycle `rollback_o`, `discard_o` and `redirect_valid_o` are each high for one cycle, `depth_o` is 0, `active_o` is 0, and `status_o` is 3'b001 (bit 0).
- R7: `abort_cond_i` while active is handled as an abort with `status_o` = 3'b100 (bit 2).
- R8: An open event while the depth equals MAX_DEPTH is handled as an abort with `status_o` = 3'b010 (bit 1). The depth does not grow past MAX_DEPTH.
- R9: `redirect_addr_o` is the address saved at the outermost open. If `mode64_i` is 1 in the cycle the abort is decided, it is given at full width. If `mode64_i` is 0, only its low 32 bits are given and the upper bits are zero.
- R10: `status_o` changes only in a cycle where `redirect_valid_o` is high. In that cycle exactly one of its bits is set.
- R11: Events taken in the same cycle follow the priority abort, then close, then open. `abort_cond_i` has no effect while no transaction is open.
- R12: After reset, `active_o`, `depth_o`, `status_o`, `fault_o`, `redirect_valid_o` and `commit_valid_o` are 0, and `evt_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_begin_i | input | 1 | Transaction open event |
| txn_end_i | input | 1 | Transaction close event |
| abort_cond_i | input | 1 | Abort condition detected during transactional execution |
| begin_fallback_i | input | ADDR_W | Recovery address that goes with an open event |
| mode64_i | input | 1 | 1 = full-width redirect address, 0 = 32-bit zero-extended |
| evt_ready_o | output | 1 | Open and close events are accepted |
| commit_valid_o | output | 1 | Commit request to the checkpoint unit |
| commit_ready_i | input | 1 | Checkpoint unit accepts the commit request |
| commit_resp_valid_i | input | 1 | One-cycle commit response strobe |
| commit_resp_ok_i | input | 1 | Commit result: 1 = success, 0 = failure |
| rollback_o | output | 1 | Request to restore the register checkpoint |
| discard_o | output | 1 | Request to drop buffered transactional stores |
| fault_o | output | 1 | Protection fault pulse |
| redirect_valid_o | output | 1 | Redirect strobe |
| redirect_addr_o | output | ADDR_W | Redirect target |
| status_o | output | 3 | Abort cause: bit0 commit fail, bit1 overflow, bit2 external |
| active_o | output | 1 | A transaction is open |
| depth_o | output | DEPTH_W | Current nesting depth |

## Verification
The bench builds the controller with MAX_DEPTH set to 3, so the overflow abort can be reached after only three nested open events. Under the default limit of 7 it would take seven. ADDR_W stays at 64 and NARROW_W at 32. With these widths, recovery addresses that have non-zero upper halves show whether the 32-bit zero-extension path and the full-width path each select the right bits. Because the depth field is only two bits wide with this limit, a wrap past the maximum would show up at once as a wrong depth.

// File: rtl/txn_nest_pkg.sv
package txn_nest_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_CREQ   = 2'd2,
      ST_CRESP  = 2'd3
   } txn_state_e;

   localparam int STAT_W   = 3;
   localparam int STAT_FAIL = 0;
   localparam int STAT_OVF  = 1;
   localparam int STAT_EXT  = 2;
endpackage

// File: rtl/txn_depth_cnt.sv
module txn_depth_cnt #(
   parameter int MAX_DEPTH = 7,
   localparam int DW = $clog2(MAX_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_i,
   input  logic          dec_i,
   input  logic          clr_i,
   output logic [DW-1:0] depth_o,
   output logic          at_max_o,
   output logic          is_one_o,
   output logic          is_zero_o
);
   localparam logic [DW-1:0] LIMIT = DW'(MAX_DEPTH);

   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      else if (dec_i) cnt_q <= cnt_q - 1'b1;
   end

   assign depth_o   = cnt_q;
   assign at_max_o  = (cnt_q == LIMIT);
   assign is_one_o  = (cnt_q == DW'(1));
   assign is_zero_o = (cnt_q == '0);

   AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);                                              // R8
   AST_INC_BELOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i) |-> (cnt_q != LIMIT));                      // R8
   AST_DEC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !clr_i && !inc_i) |-> (cnt_q != '0));               // R3
endmodule

// File: rtl/txn_fallback_reg.sv
module txn_fallback_reg #(
   parameter int ADDR_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              fire_i,
   input  logic              wide_i,
   output logic [ADDR_W-1:0] redir_addr_o
);
   logic [ADDR_W-1:0] saved_q;
   logic [ADDR_W-1:0] shaped;
   logic [ADDR_W-1:0] redir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      saved_q <= '0;
      else if (load_i) saved_q <= addr_i;
   end

   generate
      if (NARROW_W < ADDR_W) begin : g_dual_mode
         always_comb begin
            if (wide_i) shaped = saved_q;
            else        shaped = {{(ADDR_W-NARROW_W){1'b0}}, saved_q[NARROW_W-1:0]};
         end
      end else begin : g_single_mode
         always_comb shaped = saved_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      redir_q <= '0;
      else if (fire_i) redir_q <= shaped;
   end

   assign redir_addr_o = redir_q;

   AST_LOAD_FIRE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && fire_i));                                         // R2
   AST_REDIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fire_i) |-> $stable(redir_q));                         // R9
endmodule

// File: rtl/txn_ctrl_fsm.sv
module txn_ctrl_fsm
   import txn_nest_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              begin_i,
   input  logic              end_i,
   input  logic              abort_i,
   input  logic              commit_ready_i,
   input  logic              resp_valid_i,
   input  logic              resp_ok_i,
   input  logic              at_max_i,
   input  logic              is_one_i,
   input  logic              is_zero_i,
   output logic              inc_o,
   output logic              dec_o,
   output logic              clr_o,
   output logic              load_o,
   output logic              fire_o,
   output logic              evt_ready_o,
   output logic              commit_valid_o,
   output logic              fault_o,
   output logic              abort_pulse_o,
   output logic [STAT_W-1:0] status_o,
   output logic              active_o
);
   txn_state_e        st_q, st_d;
   logic              fault_d, fault_q, abort_q;
   logic [STAT_W-1:0] code_d, status_q;

   always_comb begin
      st_d    = st_q;
      inc_o   = 1'b0;
      dec_o   = 1'b0;
      clr_o   = 1'b0;
      load_o  = 1'b0;
      fire_o  = 1'b0;
      fault_d = 1'b0;
      code_d  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (end_i) begin
               fault_d = 1'b1;
            end else if (begin_i) begin
               inc_o  = 1'b1;
               load_o = 1'b1;
               st_d   = ST_ACTIVE;
            end
         end
         ST_ACTIVE: begin
            if (abort_i) begin
               fire_o           = 1'b1;
               code_d[STAT_EXT] = 1'b1;
            end else if (end_i) begin
               dec_o = 1'b1;
               if (is_one_i) st_d = ST_CREQ;
            end else if (begin_i) begin
               if (at_max_i) begin
                  fire_o           = 1'b1;
                  code_d[STAT_OVF] = 1'b1;
               end else begin
                  inc_o = 1'b1;
               end
            end
         end
         ST_CREQ: begin
            if (commit_ready_i) st_d = ST_CRESP;
         end
         ST_CRESP: begin
            if (resp_valid_i) begin
               if (resp_ok_i) begin
                  st_d = ST_IDLE;
               end else begin
                  fire_o            = 1'b1;
                  code_d[STAT_FAIL] = 1'b1;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (fire_o) begin
         clr_o = 1'b1;
         st_d  = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         fault_q  <= 1'b0;
         abort_q  <= 1'b0;
         status_q <= '0;
      end else begin
         st_q    <= st_d;
         fault_q <= fault_d;
         abort_q <= fire_o;
         if (fire_o) status_q <= code_d;
      end
   end

   assign evt_ready_o    = (st_q == ST_IDLE) || (st_q == ST_ACTIVE);
   assign commit_valid_o = (st_q == ST_CREQ);
   assign fault_o        = fault_q;
   assign abort_pulse_o  = abort_q;
   assign status_o       = status_q;
   assign active_o       = (st_q != ST_IDLE);

   AST_FAULT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> ($past(st_q) == ST_IDLE && st_q == ST_IDLE && !abort_q)); // R1
   AST_COMMIT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid_o |-> is_zero_i);                                // R3
   AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid_o && !commit_ready_i) |=> commit_valid_o);      // R4
   AST_COMMIT_OK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CRESP && resp_valid_i && resp_ok_i)
         |=> (!abort_q && st_q == ST_IDLE));                        // R5
   AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> (st_q == ST_IDLE && is_zero_i));                  // R6
   AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> ($countones(status_q) == 1));                     // R10
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !abort_q |-> $stable(status_q));                              // R10
endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
   import txn_nest_pkg::*;
#(
   parameter int MAX_DEPTH = 7,
   parameter int ADDR_W    = 64,
   parameter int NARROW_W  = 32,
   localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               txn_begin_i,
   input  logic               txn_end_i,
   input  logic               abort_cond_i,
   input  logic [ADDR_W-1:0]  begin_fallback_i,
   input  logic               mode64_i,
   output logic               evt_ready_o,
   output logic               commit_valid_o,
   input  logic               commit_ready_i,
   input  logic               commit_resp_valid_i,
   input  logic               commit_resp_ok_i,
   output logic               rollback_o,
   output logic               discard_o,
   output logic               fault_o,
   output logic               redirect_valid_o,
   output logic [ADDR_W-1:0]  redirect_addr_o,
   output logic [STAT_W-1:0]  status_o,
   output logic               active_o,
   output logic [DEPTH_W-1:0] depth_o
);
   generate
      if (MAX_DEPTH < 1) begin : g_bad_depth
         $error("MAX_DEPTH must be at least 1");
      end
      if (NARROW_W < 1 || NARROW_W > ADDR_W) begin : g_bad_narrow
         $error("NARROW_W must lie between 1 and ADDR_W");
      end
   endgenerate

   logic inc, dec, clr, load, fire;
   logic at_max, is_one, is_zero, abort_pulse;

   txn_depth_cnt #(.MAX_DEPTH(MAX_DEPTH)) u_depth (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (inc),
      .dec_i     (dec),
      .clr_i     (clr),
      .depth_o   (depth_o),
      .at_max_o  (at_max),
      .is_one_o  (is_one),
      .is_zero_o (is_zero)
   );

   txn_fallback_reg #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_fallback (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .addr_i       (begin_fallback_i),
      .fire_i       (fire),
      .wide_i       (mode64_i),
      .redir_addr_o (redirect_addr_o)
   );

   txn_ctrl_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .begin_i        (txn_begin_i),
      .end_i          (txn_end_i),
      .abort_i        (abort_cond_i),
      .commit_ready_i (commit_ready_i),
      .resp_valid_i   (commit_resp_valid_i),
      .resp_ok_i      (commit_resp_ok_i),
      .at_max_i       (at_max),
      .is_one_i       (is_one),
      .is_zero_i      (is_zero),
      .inc_o          (inc),
      .dec_o          (dec),
      .clr_o          (clr),
      .load_o         (load),
      .fire_o         (fire),
      .evt_ready_o    (evt_ready_o),
      .commit_valid_o (commit_valid_o),
      .fault_o        (fault_o),
      .abort_pulse_o  (abort_pulse),
      .status_o       (status_o),
      .active_o       (active_o)
   );

   assign rollback_o       = abort_pulse;
   assign discard_o        = abort_pulse;
   assign redirect_valid_o = abort_pulse;

   AST_FAULT_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (depth_o == '0 && !active_o && !redirect_valid_o)); // R1
   AST_ACTIVE_MATCH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_o != '0) |-> active_o);                                // R2
   AST_IGNORE_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_ready_o && $past(!evt_ready_o)) |-> (depth_o == '0));   // R4
endmodule

// File: tb/sim_txn_nest_ctrl.sv
module sim_txn_nest_ctrl;
   localparam int MAXD = 3;
   localparam int AW   = 64;
   localparam int DW   = $clog2(MAXD + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          b_i = 0, e_i = 0, a_i = 0, m64 = 1;
   logic [AW-1:0] fb = '0;
   logic          c_rdy = 0, r_vld = 0, r_ok = 0;
   logic          evt_rdy, c_vld, rb, disc, flt, rd_vld, act;
   logic [AW-1:0] rd_addr;
   logic [2:0]    stat;
   logic [DW-1:0] dep;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   txn_nest_ctrl #(.MAX_DEPTH(MAXD), .ADDR_W(AW), .NARROW_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .txn_begin_i(b_i), .txn_end_i(e_i),
      .abort_cond_i(a_i), .begin_fallback_i(fb), .mode64_i(m64),
      .evt_ready_o(evt_rdy), .commit_valid_o(c_vld), .commit_ready_i(c_rdy),
      .commit_resp_valid_i(r_vld), .commit_resp_ok_i(r_ok),
      .rollback_o(rb), .discard_o(disc), .fault_o(flt),
      .redirect_valid_o(rd_vld), .redirect_addr_o(rd_addr),
      .status_o(stat), .active_o(act), .depth_o(dep)
   );

   task automatic chk(input string req, input logic [63:0] actual, input logic [63:0] expv);
      n_chk++;
      if (actual !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, actual, expv);
      end
   endtask

   task automatic ev(input logic b, input logic e, input logic a, input logic [AW-1:0] addr);
      @(negedge clk);
      b_i = b; e_i = e; a_i = a; fb = addr;
      @(posedge clk); #1;
      b_i = 0; e_i = 0; a_i = 0;
   endtask

   task automatic idle();
      @(negedge clk); @(posedge clk); #1;
   endtask

   task automatic handshake();
      @(negedge clk); c_rdy = 1;
      @(posedge clk); #1; c_rdy = 0;
   endtask

   task automatic respond(input logic ok);
      @(negedge clk); r_vld = 1; r_ok = ok;
      @(posedge clk); #1; r_vld = 0; r_ok = 0;
   endtask

   task automatic t_reset();
      chk("R12 active", act, 0);
      chk("R12 depth", dep, 0);
      chk("R12 status", stat, 0);
      chk("R12 fault", flt, 0);
      chk("R12 redirect", rd_vld, 0);
      chk("R12 commit_valid", c_vld, 0);
      chk("R12 evt_ready", evt_rdy, 1);
   endtask

   task automatic t_fault_idle();
      ev(0, 1, 0, '0);
      chk("R1 fault pulse", flt, 1);
      chk("R1 active kept", act, 0);
      chk("R1 depth kept", dep, 0);
      chk("R1 no redirect", rd_vld, 0);
      chk("R1 no rollback", rb, 0);
      chk("R1 status kept", stat, 0);
      idle();
      chk("R1 fault one cycle", flt, 0);
   endtask

   task automatic t_commit_ok();
      ev(1, 0, 0, 64'h1111_2222_3333_4444);
      chk("R2 active set", act, 1);
      chk("R2 depth 1", dep, 1);
      ev(1, 0, 0, 64'h9999_AAAA_BBBB_CCCC);
      chk("R2 depth 2", dep, 2);
      ev(0, 1, 0, '0);
      chk("R3 inner end depth", dep, 1);
      chk("R3 no inner commit", c_vld, 0);
      ev(0, 1, 0, '0);
      chk("R3 commit at zero", c_vld, 1);
      chk("R3 depth zero", dep, 0);
      chk("R4 back-pressure", evt_rdy, 0);
      idle();
      chk("R4 valid held", c_vld, 1);
      ev(1, 0, 0, 64'hDEAD);
      chk("R4 begin ignored", dep, 0);
      chk("R4 still waiting", c_vld, 1);
      handshake();
      chk("R4 valid dropped", c_vld, 0);
      chk("R4 still blocked", evt_rdy, 0);
      ev(0, 1, 0, '0);
      chk("R4 end ignored no fault", flt, 0);
      respond(1);
      chk("R5 active cleared", act, 0);
      chk("R5 no redirect", rd_vld, 0);
      chk("R5 no rollback", rb, 0);
      chk("R5 status kept", stat, 0);
      chk("R5 ready again", evt_rdy, 1);
   endtask

   task automatic t_commit_fail();
      m64 = 1;
      ev(1, 0, 0, 64'hFEDC_BA98_7654_3210);
      ev(0, 1, 0, '0);
      handshake();
      respond(0);
      chk("R6 redirect", rd_vld, 1);
      chk("R6 rollback", rb, 1);
      chk("R6 discard", disc, 1);
      chk("R6 status", stat, 3'b001);
      chk("R6 active", act, 0);
      chk("R6 depth", dep, 0);
      chk("R9 wide address", rd_addr, 64'hFEDC_BA98_7654_3210);
      idle();
      chk("R6 redirect one cycle", rd_vld, 0);
      chk("R10 status held", stat, 3'b001);
   endtask

   task automatic t_ext_abort_narrow();
      ev(1, 0, 0, 64'hABCD_0000_1234_5678);
      ev(1, 0, 0, 64'h5555_5555_6666_6666);
      m64 = 0;
      ev(0, 0, 1, '0);
      chk("R7 status", stat, 3'b100);
      chk("R7 redirect", rd_vld, 1);
      chk("R7 depth", dep, 0);
      chk("R9 narrow outer address", rd_addr, 64'h0000_0000_1234_5678);
      m64 = 1;
   endtask

   task automatic t_overflow();
      ev(1, 0, 0, 64'h0000_0007_0000_0100);
      ev(1, 0, 0, 64'h1);
      ev(1, 0, 0, 64'h2);
      chk("R8 at max", dep, MAXD);
      chk("R8 no early abort", rd_vld, 0);
      ev(1, 0, 0, 64'h3);
      chk("R8 status", stat, 3'b010);
      chk("R8 redirect", rd_vld, 1);
      chk("R8 depth cleared", dep, 0);
      chk("R2 outer kept", rd_addr, 64'h0000_0007_0000_0100);
   endtask

   task automatic t_priority();
      ev(0, 0, 1, '0);
      chk("R11 idle abort no redirect", rd_vld, 0);
      chk("R11 idle abort status", stat, 3'b010);
      chk("R11 idle abort active", act, 0);
      ev(1, 0, 0, 64'h40);
      ev(1, 0, 0, 64'h80);
      ev(1, 1, 0, '0);
      chk("R11 end beats begin", dep, 1);
      ev(1, 1, 1, '0);
      chk("R11 abort beats all", stat, 3'b100);
      chk("R11 abort redirect", rd_vld, 1);
      chk("R11 abort depth", dep, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      idle();
      t_reset();
      t_fault_idle();
      t_commit_ok();
      t_commit_fail();
      t_ext_abort_narrow();
      t_overflow();
      t_priority();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule